// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. A configuration snapshot is taken when the channel is enabled. It holds a source start address, a destination start address, an element count, a completion threshold and a control word. The control word selects the element width, the burst size, per-side address stepping, the request mode and circular operation. Each element is moved by a read from the source followed by a write to the destination, over a single valid/ready memory request port with a separate read-return path. The channel reports a running element index, a sticky completion flag and a masked interrupt.

In software mode a transfer starts as soon as the channel is enabled. In hardware mode a peripheral request, sampled at each unit boundary, lets one unit (one burst) through. A fixed source combined with an incrementing destination in software mode selects fill operation automatically. In fill operation the source is read once, its value is written to every destination element, and the channel asks the surrounding arbiter to hold the bus. A global freeze input stalls progress without losing the index. A disable request takes effect only at the end of the current unit.

Back-pressure rules on the request port: once `mem_valid` is high it stays high, and `mem_write`, `mem_addr`, `mem_size` and `mem_wdata` stay unchanged, until a cycle with `mem_ready` high. A read's data returns on a later cycle with `mem_rvalid` high. That return path has no ready, and only one read is ever outstanding.

Top module: `dmach_engine`

## Requirements
- R1: The width code steps an incrementing address by 1 byte (code 0), 2 bytes (code 1) or 4 bytes (code 2) per element, and the code is driven on `mem_size`. Source and destination share the width.
- R2: Each side has its own increment enable. With the enable clear, every access on that side uses the start address.
- R3: A unit is 1 element (burst code 0), 4 elements (code 1) or 8 elements (code 2). In hardware mode a peripheral request seen with the channel idle between units admits exactly one unit.
- R4: `cfg_len_m1` holds the element count minus one. After that many plus one elements have been written, a non-circular channel drops `ch_on` by itself, and `ch_index` then equals the element count.
- R5: `done_flag` rises on the write of element number `cfg_thr_m1` (counting from 0) and is sticky. `irq` is `done_flag` AND `cfg_irq_en`. A `done_clr` pulse clears the flag. A set in the same cycle as a clear wins.
- R6: In software mode data moves right after enable. In hardware mode no request is issued while `periph_req` is low.
- R7: Circular operation applies only in hardware mode. After the last element the index returns to 0, both addresses return to their start values, and `ch_on` stays high. In software mode the circular bit has no effect.
- R8: With source increment clear, destination increment set and software mode, the source is read exactly once, every write carries that value, and `bus_hold` is high while the channel is on.
- R9: While `freeze` is high, no new memory request is issued and `ch_index` holds. After release the transfer completes normally.
- R10: `ch_disable` takes effect at the next unit boundary, and `ch_on` reads high until then. A following `ch_enable` restarts `ch_index` at 0.
- R11: A request held while `mem_ready` is low keeps its valid, direction, address and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_len_m1 | input | CW | Element count minus one |
| cfg_thr_m1 | input | CW | Element number that raises the completion flag |
| cfg_width | input | 2 | Element width code |
| cfg_burst | input | 2 | Burst size code |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_hw_req | input | 1 | 1 = hardware request mode, 0 = software |
| cfg_circular | input | 1 | Circular operation request |
| cfg_irq_en | input | 1 | Interrupt mask (1 = pass) |
| ch_enable | input | 1 | Enable pulse; samples the configuration |
| ch_disable | input | 1 | Disable request pulse |
| freeze | input | 1 | Global freeze |
| periph_req | input | 1 | Peripheral request level |
| done_clr | input | 1 | Write-one-to-clear of the completion flag |
| ch_on | output | 1 | Channel enabled |
| ch_index | output | CW+1 | Elements moved so far |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Masked completion interrupt |
| bus_hold | output | 1 | Fill transfer in progress; do not pre-empt |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Request address |
| mem_size | output | 2 | Element width code of the request |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
Two pairs of events can coincide. The first is the threshold write that sets the completion flag and a clear request. The bench holds `done_clr` high through a whole transfer and expects the flag to read high for exactly one cycle: the set wins in its own cycle and the clear takes it the next. The second is a disable request and a unit boundary. A disable issued early in an 8-element unit must leave `ch_on` high until the eighth write of that unit, and the bench checks that exactly 8 writes occurred and the index stopped at 8. These checks are repeated under a memory that withholds ready one cycle in four.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WR    = 2'd3
  } dmach_state_e;

  typedef struct packed {
    logic [1:0] wcode;
    logic [1:0] burst;
    logic       src_inc;
    logic       dst_inc;
    logic       hw_req;
    logic       circ;
  } dmach_ctrl_t;

  // Beats in one unit, minus one.
  function automatic logic [2:0] unit_beats_m1(input logic [1:0] code);
    case (code)
      2'd1:    unit_beats_m1 = 3'd3;
      2'd2:    unit_beats_m1 = 3'd7;
      default: unit_beats_m1 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmach_addr_step.sv
module dmach_addr_step #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          step,
  input  logic          inc_en,
  input  logic [1:0]    wcode,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] stride;
  assign stride = AW'(1) << wcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr <= '0;
    else if (load)          addr <= start;
    else if (step && inc_en) addr <= addr + stride;
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc_en) |=> $stable(addr)); // R2

endmodule

// File: rtl/dmach_flag.sv
module dmach_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic done,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   done <= 1'b0;
    else if (set) done <= 1'b1;
    else if (clr) done <= 1'b0;
  end

  assign irq = done & irq_en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> done); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done); // R5

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          freeze,
  input  logic          preq,
  input  logic          hw,
  input  logic          circ,
  input  logic          fill,
  input  logic [1:0]    burst,
  input  logic [CW-1:0] len_m1,
  input  logic [CW-1:0] thr_m1,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  output logic          start,
  output logic          reload,
  output logic          step,
  output logic          take_rdata,
  output logic          set_done,
  output logic          on,
  output logic [CW:0]   idx,
  output logic          mem_valid,
  output logic          mem_write
);

  dmach_state_e state;
  logic         stop_pend;
  logic         have_data;
  logic         issued;
  logic [2:0]   beat;
  logic         rd_hs, wr_hs, last_elem, last_beat, go, stop_now;

  assign mem_valid  = ((state == ST_RD) || (state == ST_WR)) && (!freeze || issued);
  assign mem_write  = (state == ST_WR);
  assign rd_hs      = (state == ST_RD) && mem_valid && mem_ready;
  assign wr_hs      = (state == ST_WR) && mem_valid && mem_ready;
  assign last_elem  = (idx == {1'b0, len_m1});
  assign last_beat  = (beat == unit_beats_m1(burst));
  assign stop_now   = stop_pend || dis_req;
  assign go         = on && !freeze && (!hw || preq);
  assign start      = en_req && !on;
  assign reload     = wr_hs && last_elem && circ;
  assign step       = wr_hs;
  assign take_rdata = (state == ST_RWAIT) && mem_rvalid;
  assign set_done   = wr_hs && (idx == {1'b0, thr_m1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      on        <= 1'b0;
      stop_pend <= 1'b0;
      have_data <= 1'b0;
      issued    <= 1'b0;
      beat      <= '0;
      idx       <= '0;
    end else begin
      issued <= mem_valid && !mem_ready;
      if (start) begin
        on        <= 1'b1;
        idx       <= '0;
        stop_pend <= 1'b0;
        have_data <= 1'b0;
        beat      <= '0;
        state     <= ST_IDLE;
      end else begin
        if (dis_req && on) stop_pend <= 1'b1;
        case (state)
          ST_IDLE: begin
            if (on && stop_now) begin
              on        <= 1'b0;
              stop_pend <= 1'b0;
            end else if (go) begin
              beat  <= '0;
              state <= (fill && have_data) ? ST_WR : ST_RD;
            end
          end
          ST_RD: if (rd_hs) state <= ST_RWAIT;
          ST_RWAIT: begin
            if (mem_rvalid) begin
              have_data <= 1'b1;
              state     <= ST_WR;
            end
          end
          default: begin
            if (wr_hs) begin
              idx  <= idx + (CW+1)'(1);
              beat <= beat + 3'd1;
              if (last_elem) begin
                state <= ST_IDLE;
                if (circ) begin
                  idx <= '0;
                  if (stop_now) begin
                    on        <= 1'b0;
                    stop_pend <= 1'b0;
                  end
                end else begin
                  on        <= 1'b0;
                  stop_pend <= 1'b0;
                end
              end else if (last_beat) begin
                state <= ST_IDLE;
                if (stop_now) begin
                  on        <= 1'b0;
                  stop_pend <= 1'b0;
                end
              end else begin
                state <= (fill && have_data) ? ST_WR : ST_RD;
              end
            end
          end
        endcase
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write))); // R11
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= ({1'b0, len_m1} + (CW+1)'(1))); // R4
  AST_FREEZE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !mem_valid && !start) |=> $stable(idx)); // R9
  AST_OFF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on) |-> ($past(state) == ST_IDLE || $past(wr_hs))); // R10
  AST_HW_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && hw && !preq) |=> (state == ST_IDLE)); // R6

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_len_m1,
  input  logic [CW-1:0] cfg_thr_m1,
  input  logic [1:0]    cfg_width,
  input  logic [1:0]    cfg_burst,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          cfg_hw_req,
  input  logic          cfg_circular,
  input  logic          cfg_irq_en,
  input  logic          ch_enable,
  input  logic          ch_disable,
  input  logic          freeze,
  input  logic          periph_req,
  input  logic          done_clr,
  output logic          ch_on,
  output logic [CW:0]   ch_index,
  output logic          done_flag,
  output logic          irq,
  output logic          bus_hold,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  dmach_ctrl_t                ctrl_q;
  logic [CW-1:0]              len_q, thr_q;
  logic [NSIDE-1:0][AW-1:0]   base_q, load_val, addr_cur;
  logic [NSIDE-1:0]           inc;
  logic [DW-1:0]              data_q;
  logic                       start, reload, step, take_rdata, set_done;
  logic                       fill, circ_eff;

  assign fill     = !ctrl_q.src_inc && ctrl_q.dst_inc && !ctrl_q.hw_req;
  assign circ_eff = ctrl_q.circ && ctrl_q.hw_req;
  assign inc      = {ctrl_q.dst_inc, ctrl_q.src_inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      thr_q  <= '0;
      base_q <= '0;
      data_q <= '0;
    end else begin
      if (start) begin
        ctrl_q    <= '{wcode: cfg_width, burst: cfg_burst, src_inc: cfg_src_inc,
                       dst_inc: cfg_dst_inc, hw_req: cfg_hw_req, circ: cfg_circular};
        len_q     <= cfg_len_m1;
        thr_q     <= cfg_thr_m1;
        base_q[0] <= cfg_src_addr;
        base_q[1] <= cfg_dst_addr;
      end
      if (take_rdata) data_q <= mem_rdata;
    end
  end

  assign load_val[0] = start ? cfg_src_addr : base_q[0];
  assign load_val[1] = start ? cfg_dst_addr : base_q[1];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dmach_addr_step #(.AW(AW)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start || reload),
      .start  (load_val[s]),
      .step   (step),
      .inc_en (inc[s]),
      .wcode  (ctrl_q.wcode),
      .addr   (addr_cur[s])
    );
  end

  dmach_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_req     (ch_enable),
    .dis_req    (ch_disable),
    .freeze     (freeze),
    .preq       (periph_req),
    .hw         (ctrl_q.hw_req),
    .circ       (circ_eff),
    .fill       (fill),
    .burst      (ctrl_q.burst),
    .len_m1     (len_q),
    .thr_m1     (thr_q),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .start      (start),
    .reload     (reload),
    .step       (step),
    .take_rdata (take_rdata),
    .set_done   (set_done),
    .on         (ch_on),
    .idx        (ch_index),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write)
  );

  dmach_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (set_done),
    .clr    (done_clr),
    .irq_en (cfg_irq_en),
    .done   (done_flag),
    .irq    (irq)
  );

  assign mem_addr  = mem_write ? addr_cur[1] : addr_cur[0];
  assign mem_size  = ctrl_q.wcode;
  assign mem_wdata = data_q;
  assign bus_hold  = ch_on && fill;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata))); // R11
  AST_HOLD_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> ch_on); // R8
  AST_SW_NOT_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ch_on && !ctrl_q.hw_req && ch_index == {1'b0, len_q}) |=> !ch_on); // R7

endmodule

// File: tb/test_dmach_engine.sv
module test_dmach_engine;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [CW-1:0] cfg_len_m1 = '0, cfg_thr_m1 = '0;
  logic [1:0]    cfg_width = '0, cfg_burst = '0;
  logic          cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_hw_req = 1'b0;
  logic          cfg_circular = 1'b0, cfg_irq_en = 1'b0;
  logic          ch_enable = 1'b0, ch_disable = 1'b0, freeze = 1'b0;
  logic          periph_req = 1'b0, done_clr = 1'b0;
  logic          ch_on, done_flag, irq, bus_hold;
  logic [CW:0]   ch_index;
  logic          mem_valid, mem_ready, mem_write;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dmach_engine #(.AW(AW), .DW(DW), .CW(CW)) i_dmach_engine (.*);

  // Memory model
  logic [1:0]  rdy_cyc = '0;
  logic        rdy_mode = 1'b0;
  int          wr_n = 0;
  int          rd_n = 0;
  logic [31:0] wa [0:1023];
  logic [31:0] wd [0:1023];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
  endfunction

  assign mem_ready = rdy_mode ? (rdy_cyc != 2'd3) : 1'b1;

  always @(posedge clk) begin
    rdy_cyc    <= rdy_cyc + 2'd1;
    mem_rvalid <= mem_valid && mem_ready && !mem_write;
    mem_rdata  <= pat(mem_addr);
    if (mem_valid && mem_ready && !mem_write) rd_n <= rd_n + 1;
    if (mem_valid && mem_ready && mem_write) begin
      if (wr_n < 1024) begin
        wa[wr_n] <= mem_addr;
        wd[wr_n] <= mem_wdata;
      end
      wr_n <= wr_n + 1;
    end
  end

  // Request-hold monitor (R11), sampled on the falling edge
  logic        pv = 1'b0, pr = 1'b0, pw = 1'b0;
  logic [31:0] pa = '0, pd = '0;
  int          hold_viol = 0;
  always @(negedge clk) begin
    if (rst_n && pv && !pr &&
        !(mem_valid && mem_write == pw && mem_addr == pa && mem_wdata == pd))
      hold_viol++;
    pv = mem_valid; pr = mem_ready; pw = mem_write; pa = mem_addr; pd = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_enable();
    @(negedge clk); ch_enable = 1'b1;
    @(negedge clk); ch_enable = 1'b0;
  endtask

  task automatic wait_off();
    for (int i = 0; i < 4000 && ch_on; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] w, input logic [1:0] b, input bit si,
                       input bit di, input bit hw, input bit circ,
                       input int n, input int thr);
    cfg_src_addr = 32'h0000_1000; cfg_dst_addr = 32'h0000_8000;
    cfg_width = w; cfg_burst = b; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_hw_req = hw; cfg_circular = circ;
    cfg_len_m1 = CW'(n - 1); cfg_thr_m1 = CW'(thr);
  endtask

  // Software-mode run with full checking of the write log
  task automatic run_sw(input logic [1:0] w, input logic [1:0] b, input bit si,
                        input bit di, input int n);
    int wb, rb, bad_a, bad_d;
    logic [31:0] ea, ed, ga, gd;
    bit hold_seen, fillm;
    fillm = !si && di;
    setup(w, b, si, di, 1'b0, 1'b0, n, n - 1);
    wb = wr_n; rb = rd_n; hold_seen = 0;
    pulse_enable();
    for (int i = 0; i < 4000 && ch_on; i++) begin
      if (bus_hold) hold_seen = 1;
      @(negedge clk);
    end
    chk(wr_n - wb == n && ch_index == (CW+1)'(n), "R4 count/index",
        32'(ch_index), 32'(n));
    bad_a = 0; bad_d = 0; ga = 0; gd = 0; ea = 0; ed = 0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] xa, xd;
      xa = cfg_dst_addr + (di ? (32'(k) << w) : 32'd0);
      xd = pat(cfg_src_addr + (si ? (32'(k) << w) : 32'd0));
      if (wa[wb + k] != xa && bad_a == 0) begin bad_a = 1; ga = wa[wb + k]; ea = xa; end
      if (wd[wb + k] != xd && bad_d == 0) begin bad_d = 1; gd = wd[wb + k]; ed = xd; end
    end
    chk(bad_a == 0, "R1/R2 dest address", ga, ea);
    chk(bad_d == 0, "R1/R2 data from source", gd, ed);
    chk(rd_n - rb == (fillm ? 1 : n), "R8 read count", 32'(rd_n - rb),
        32'(fillm ? 1 : n));
    chk(hold_seen == fillm, "R8 bus_hold", 32'(hold_seen), 32'(fillm));
  endtask

  initial begin
    int wb, ixs;
    bit bad, vseen;
    int dseen;
    repeat (3) @(negedge clk);
    // Reset state
    chk(!ch_on && ch_index == 0 && !done_flag && !irq && !mem_valid && !bus_hold,
        "reset state", {28'd0, ch_on, done_flag, irq, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: width x burst x increment pairs (R1 R2 R3 R4 R8 R11)
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 4; m++) begin
          rdy_mode = ((w + b + m) % 2) == 1;
          run_sw(2'(w), 2'(b), m[0], m[1], 8);
        end
    rdy_mode = 1'b0;

    // R6/R3: hardware mode, burst of 4, 8 elements
    setup(2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8, 7);
    wb = wr_n;
    pulse_enable();
    vseen = 0;
    for (int i = 0; i < 12; i++) begin
      if (mem_valid) vseen = 1;
      @(negedge clk);
    end
    chk(!vseen && wr_n == wb && ch_on, "R6 hw mode waits", 32'(vseen), 32'd0);
    periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_n - wb == 4 && ch_index == 4 && ch_on, "R3 one unit of 4 per request",
        32'(wr_n - wb), 32'd4);
    periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_n - wb == 8 && !ch_on, "R4 hw run ends after 8", 32'(wr_n - wb), 32'd8);

    // R3: burst of 8 in hardware mode
    setup(2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16, 15);
    wb = wr_n;
    pulse_enable();
    periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(wr_n - wb == 8 && ch_on, "R3 one unit of 8 per request", 32'(wr_n - wb), 32'd8);
    @(negedge clk); ch_disable = 1'b1; @(negedge clk); ch_disable = 1'b0;
    repeat (3) @(negedge clk);

    // R7: circular in hardware mode, 4 words
    setup(2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4, 1);
    wb = wr_n;
    pulse_enable();
    periph_req = 1'b1;
    for (int i = 0; i < 200 && (wr_n - wb) < 6; i++) @(negedge clk);
    periph_req = 1'b0;
    repeat (20) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 6; k++)
      if (wa[wb + k] != cfg_dst_addr + 32'((k % 4) * 4)) bad = 1;
    chk(!bad, "R7 addresses wrap to start", wa[wb + 4], cfg_dst_addr);
    chk(ch_on && ch_index == (CW+1)'((wr_n - wb) % 4), "R7 index wraps, stays on",
        32'(ch_index), 32'((wr_n - wb) % 4));
    @(negedge clk); ch_disable = 1'b1; @(negedge clk); ch_disable = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ch_on, "R10 disable while idle", 32'(ch_on), 32'd0);

    // R7: circular bit ignored in software mode
    setup(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4, 3);
    wb = wr_n;
    pulse_enable();
    wait_off();
    repeat (5) @(negedge clk);
    chk(!ch_on && wr_n - wb == 4 && ch_index == 4, "R7 sw circular ignored",
        32'(wr_n - wb), 32'd4);

    // R5: threshold, mask, clear
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    cfg_irq_en = 1'b0;
    setup(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8, 2);
    wb = wr_n; dseen = -1;
    pulse_enable();
    for (int i = 0; i < 4000 && ch_on; i++) begin
      if (done_flag && dseen < 0) dseen = wr_n - wb;
      @(negedge clk);
    end
    chk(dseen == 3, "R5 flag rises on element 2", 32'(dseen), 32'd3);
    chk(done_flag && !irq, "R5 flag sticky, irq masked", {30'd0, done_flag, irq}, 32'd2);
    cfg_irq_en = 1'b1; #1;
    chk(irq, "R5 irq unmasked", 32'(irq), 32'd1);
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk(!done_flag && !irq, "R5 clear", {30'd0, done_flag, irq}, 32'd0);

    // R5: set and clear in the same cycle
    setup(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 6, 2);
    rdy_mode = 1'b1;
    done_clr = 1'b1;
    dseen = 0;
    pulse_enable();
    for (int i = 0; i < 4000 && ch_on; i++) begin
      if (done_flag) dseen++;
      @(negedge clk);
    end
    repeat (3) begin if (done_flag) dseen++; @(negedge clk); end
    done_clr = 1'b0;
    chk(dseen == 1, "R5 set wins over clear", 32'(dseen), 32'd1);
    rdy_mode = 1'b0;

    // R9: freeze
    setup(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16, 15);
    wb = wr_n;
    pulse_enable();
    for (int i = 0; i < 200 && (wr_n - wb) < 3; i++) @(negedge clk);
    freeze = 1'b1;
    repeat (3) @(negedge clk);
    ixs = int'(ch_index); vseen = 0; bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_valid) vseen = 1;
      if (int'(ch_index) != ixs) bad = 1;
      @(negedge clk);
    end
    chk(!vseen && !bad && ch_on, "R9 freeze stalls, index held", 32'(ch_index),
        32'(ixs));
    freeze = 1'b0;
    wait_off();
    chk(wr_n - wb == 16 && ch_index == 16, "R9 resumes to completion",
        32'(wr_n - wb), 32'd16);

    // R10: disable at unit boundary, then restart
    rdy_mode = 1'b1;
    setup(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16, 15);
    wb = wr_n;
    pulse_enable();
    for (int i = 0; i < 200 && (wr_n - wb) < 1; i++) @(negedge clk);
    ch_disable = 1'b1; @(negedge clk); ch_disable = 1'b0;
    chk(ch_on, "R10 on stays set mid-unit", 32'(ch_on), 32'd1);
    wait_off();
    repeat (5) @(negedge clk);
    chk(!ch_on && wr_n - wb == 8 && ch_index == 8, "R10 stop after unit",
        32'(wr_n - wb), 32'd8);
    setup(2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4, 3);
    @(negedge clk); ch_enable = 1'b1; @(negedge clk); ch_enable = 1'b0;
    chk(ch_on && ch_index == 0, "R10 re-enable resets index", 32'(ch_index), 32'd0);
    wait_off();
    rdy_mode = 1'b0;

    chk(hold_viol == 0, "R11 request held under back-pressure", 32'(hold_viol), 32'd0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule